// File: doc/BRIEF.md
# Mode-Selectable Baud Rate Generator

This block is a free-running programmable clock divider that times a serial port. An 8-bit divisor N and two mode inputs set the length of one bit period: (N+1) times 4 input clocks for clocked (synchronous) operation, and (N+1) times 16 or (N+1) times 64 input clocks for the fast and slow asynchronous rates. At the end of every bit period the block raises a one-cycle `baud_tick`.

In the asynchronous rates a second output, `sample_tick`, pulses 16 times per bit period, evenly spaced. A receiver uses it to place its samples inside a bit. The 16th sample pulse of a period falls in the same cycle as `baud_tick`.

The generator counts only while `port_en` is high, and it starts a fresh period each time the port is enabled. The divisor and mode inputs are captured when the port is enabled and again at each period boundary. A change made in the middle of a period therefore takes effect in the following period.

Top module: `brg_baud_gen`

## Requirements
- R1: With `sync_sel`=1 (whatever `fast_sel` is), consecutive `baud_tick` pulses are exactly 4*(N+1) clocks apart.
- R2: With `sync_sel`=0 and `fast_sel`=1, consecutive `baud_tick` pulses are exactly 16*(N+1) clocks apart.
- R3: With `sync_sel`=0 and `fast_sel`=0, consecutive `baud_tick` pulses are exactly 64*(N+1) clocks apart.
- R4: The first clock edge that samples `port_en` high after it was low starts a new period. The first `baud_tick` is high in the cycle that follows edge P*(N+1) after that start edge, where P is the current prescale.
- R5: After any clock edge that samples `port_en` low, both `baud_tick` and `sample_tick` are low. They stay low until the port is enabled again, and the next enable restarts the phase as in R4.
- R6: `sample_tick` pulses exactly 16 times per bit period in both asynchronous rates. These pulses are N+1 clocks apart at the fast rate and 4*(N+1) clocks apart at the slow rate, and the first one comes that far after a `baud_tick`. In synchronous mode `sample_tick` never pulses.
- R7: A change of `divisor`, `sync_sel` or `fast_sel` during a period does not alter that period. It governs every period from the next `baud_tick` on.
- R8: `baud_tick` is high for exactly one clock cycle per period.
- R9: While `rst_n` is low, both outputs are low and the generator is stopped. After reset is released with `port_en` high, counting restarts as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that the generator divides |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Serial port enable; the generator runs while it is high |
| sync_sel | input | 1 | 1 selects synchronous timing (prescale 4) |
| fast_sel | input | 1 | In asynchronous timing, 1 selects prescale 16 and 0 selects prescale 64 |
| divisor | input | DIV_W (8) | Divisor N; the period is P*(N+1) clocks |
| baud_tick | output | 1 | One-cycle pulse at the end of each bit period |
| sample_tick | output | 1 | One-cycle pulse 16 times per bit period in asynchronous timing |

## Verification
The bench builds the generator with its default parameters: an 8-bit divisor, prescales of 4, 16 and 64, and 16 sample pulses per bit. This lets it run divisor values from 0 up to the full-scale 255 in every rate, including the longest period of 16384 clocks. With these parameters the fast and slow rates use sample spacings of one and four divisor units, so both masking paths of the sample pulse are exercised. The defaults also keep every period short enough to test disabling in mid-period, changing the configuration in mid-period and resetting in mid-period.

// File: rtl/brg_pkg.sv
package brg_pkg;

    typedef enum logic [1:0] {
        RATE_SYNC = 2'd0,
        RATE_FAST = 2'd1,
        RATE_SLOW = 2'd2
    } rate_e;

    // Synchronous selection overrides the speed selection.
    function automatic rate_e decode_rate(input logic sync_sel, input logic fast_sel);
        if (sync_sel) begin
            return RATE_SYNC;
        end
        if (fast_sel) begin
            return RATE_FAST;
        end
        return RATE_SLOW;
    endfunction

endpackage

// File: rtl/brg_unit_timer.sv
// Counts divisor units of (N+1) input clocks.
module brg_unit_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             unit_end_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d    = state_q;
        unit_end_o = run_i && (state_q.cnt == div_i);
        if (!run_i || unit_end_o) begin
            state_d.cnt = '0;
        end else begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R7: the divisor is reloaded only at a boundary, so the count never passes it
    a_r7_unit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.cnt <= div_i);

    // R5: a stopped timer holds at zero
    a_r5_unit_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (state_q.cnt == '0));

endmodule

// File: rtl/brg_phase_counter.sv
// Counts divisor units within one bit period and derives period and sample ends.
module brg_phase_counter
    import brg_pkg::*;
#(
    parameter int SYNC_PRE   = 4,
    parameter int FAST_PRE   = 16,
    parameter int SLOW_PRE   = 64,
    parameter int OVERSAMPLE = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run_i,
    input  logic  unit_end_i,
    input  rate_e rate_i,
    output logic  period_end_o,
    output logic  sub_end_o
);

    localparam int MAX_PRE0 = (SYNC_PRE > FAST_PRE) ? SYNC_PRE : FAST_PRE;
    localparam int MAX_PRE  = (MAX_PRE0 > SLOW_PRE) ? MAX_PRE0 : SLOW_PRE;
    localparam int PH_W     = (MAX_PRE > 2) ? $clog2(MAX_PRE) : 1;

    localparam logic [PH_W-1:0] SYNC_LAST = PH_W'(SYNC_PRE - 1);
    localparam logic [PH_W-1:0] FAST_LAST = PH_W'(FAST_PRE - 1);
    localparam logic [PH_W-1:0] SLOW_LAST = PH_W'(SLOW_PRE - 1);
    // Prescales are powers of two: sample spacing in units, minus one, as a mask.
    localparam logic [PH_W-1:0] FAST_MASK = PH_W'(FAST_PRE / OVERSAMPLE - 1);
    localparam logic [PH_W-1:0] SLOW_MASK = PH_W'(SLOW_PRE / OVERSAMPLE - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } state_t;

    state_t          state_d, state_q;
    logic [PH_W-1:0] last_ph;
    logic [PH_W-1:0] sub_mask;
    logic            async_mode;

    always_comb begin
        case (rate_i)
            RATE_SYNC: begin last_ph = SYNC_LAST; sub_mask = '0;        async_mode = 1'b0; end
            RATE_FAST: begin last_ph = FAST_LAST; sub_mask = FAST_MASK; async_mode = 1'b1; end
            default:   begin last_ph = SLOW_LAST; sub_mask = SLOW_MASK; async_mode = 1'b1; end
        endcase

        period_end_o = unit_end_i && (state_q.ph == last_ph);
        sub_end_o    = unit_end_i && async_mode && ((state_q.ph & sub_mask) == sub_mask);

        state_d = state_q;
        if (!run_i || period_end_o) begin
            state_d.ph = '0;
        end else if (unit_end_i) begin
            state_d.ph = state_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R1 R2 R3: the phase never runs past the last unit of the selected prescale
    a_r3_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.ph <= last_ph);

endmodule

// File: rtl/brg_baud_gen.sv
module brg_baud_gen
    import brg_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int SYNC_PRE   = 4,
    parameter int FAST_PRE   = 16,
    parameter int SLOW_PRE   = 64,
    parameter int OVERSAMPLE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic             sync_sel,
    input  logic             fast_sel,
    input  logic [DIV_W-1:0] divisor,
    output logic             baud_tick,
    output logic             sample_tick
);

    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] div;
        rate_e            rate;
        logic             tick;
        logic             sub;
    } state_t;

    state_t state_d, state_q;
    logic   active;
    logic   restart;
    logic   unit_end;
    logic   period_end;
    logic   sub_end;

    brg_unit_timer #(
        .DIV_W (DIV_W)
    ) u_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (active),
        .div_i      (state_q.div),
        .unit_end_o (unit_end)
    );

    brg_phase_counter #(
        .SYNC_PRE   (SYNC_PRE),
        .FAST_PRE   (FAST_PRE),
        .SLOW_PRE   (SLOW_PRE),
        .OVERSAMPLE (OVERSAMPLE)
    ) u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (active),
        .unit_end_i   (unit_end),
        .rate_i       (state_q.rate),
        .period_end_o (period_end),
        .sub_end_o    (sub_end)
    );

    always_comb begin
        active  = state_q.run && port_en;
        restart = port_en && !state_q.run;

        state_d      = state_q;
        state_d.run  = port_en;
        state_d.tick = period_end;
        state_d.sub  = sub_end;
        // Configuration is captured only at enable and at period boundaries.
        if (restart || period_end) begin
            state_d.div  = divisor;
            state_d.rate = decode_rate(sync_sel, fast_sel);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.rate <= RATE_SLOW;
        end else begin
            state_q <= state_d;
        end
    end

    assign baud_tick   = state_q.tick;
    assign sample_tick = state_q.sub;

    // R5: a disabled port yields no pulses on the following cycle
    a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!baud_tick && !sample_tick));

    // R8: the period pulse lasts one cycle
    a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick);

    // R6: synchronous timing gives no sample pulses
    a_r6_sync_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.rate == RATE_SYNC) |=> !sample_tick);

    // R4: a restart begins a full period, so no pulse comes right after it
    a_r4_no_tick_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !baud_tick);

endmodule

// File: tb/tb_brg_baud_gen.sv
module tb_brg_baud_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0;
    logic       sync_sel = 1'b0;
    logic       fast_sel = 1'b0;
    logic [7:0] divisor = 8'd0;
    logic       baud_tick;
    logic       sample_tick;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    brg_baud_gen dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_en     (port_en),
        .sync_sel    (sync_sel),
        .fast_sel    (fast_sel),
        .divisor     (divisor),
        .baud_tick   (baud_tick),
        .sample_tick (sample_tick)
    );

    // sync, fast, divisor, expected prescale
    typedef struct packed {
        logic       sync;
        logic       fast;
        logic [7:0] div;
        logic [6:0] pre;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 8'd0,   7'd4},
        '{1'b1, 1'b1, 8'd3,   7'd4},
        '{1'b0, 1'b1, 8'd0,   7'd16},
        '{1'b0, 1'b1, 8'd2,   7'd16},
        '{1'b0, 1'b0, 8'd0,   7'd64},
        '{1'b0, 1'b0, 8'd1,   7'd64},
        '{1'b0, 1'b1, 8'd255, 7'd16},
        '{1'b1, 1'b0, 8'd255, 7'd4},
        '{1'b0, 1'b0, 8'd255, 7'd64},
        '{1'b1, 1'b0, 8'd7,   7'd4}
    };

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!baud_tick && n < 70000);
    endtask

    task automatic stop_port();
        @(negedge clk);
        port_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        int gap;
        int subs;
        int first_sub;
        int per;
        string req;

        // R9: reset state
        repeat (3) @(negedge clk);
        check_eq("R9 tick in reset", int'(baud_tick), 0);
        check_eq("R9 sample in reset", int'(sample_tick), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R5 tick while disabled", int'(baud_tick), 0);

        // Table walk: latency, period, pulse width, sample count and spacing
        for (int i = 0; i < NVEC; i++) begin
            vec_t v = VECS[i];
            per = int'(v.pre) * (int'(v.div) + 1);
            req = v.sync ? "R1" : (v.fast ? "R2" : "R3");
            stop_port();
            sync_sel = v.sync;
            fast_sel = v.fast;
            divisor  = v.div;
            port_en  = 1'b1;
            wait_tick(n);
            check_eq({"R4 first tick latency ", req}, n, per + 1);
            gap = 0;
            subs = 0;
            first_sub = 0;
            do begin
                @(negedge clk);
                gap++;
                if (gap == 1) check_eq("R8 tick width", int'(baud_tick), 0);
                if (sample_tick) begin
                    subs++;
                    if (first_sub == 0) first_sub = gap;
                end
            end while (!baud_tick && gap < 70000);
            check_eq({req, " period"}, gap, per);
            check_eq("R6 sample count", subs, v.sync ? 0 : 16);
            if (!v.sync) check_eq("R6 sample spacing", first_sub, per / 16);
        end

        // R5: disable in mid-period, stay quiet, then restart phase
        stop_port();
        sync_sel = 1'b0;
        fast_sel = 1'b1;
        divisor  = 8'd3;
        port_en  = 1'b1;
        repeat (20) @(negedge clk);
        port_en = 1'b0;
        subs = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (baud_tick || sample_tick) subs++;
        end
        check_eq("R5 pulses while disabled", subs, 0);
        port_en = 1'b1;
        wait_tick(n);
        check_eq("R5 restart latency", n, 65);

        // R7: divisor change in mid-period applies from the next boundary
        stop_port();
        sync_sel = 1'b1;
        fast_sel = 1'b0;
        divisor  = 8'd4;
        port_en  = 1'b1;
        wait_tick(n);
        check_eq("R4 sync latency", n, 21);
        repeat (5) @(negedge clk);
        divisor = 8'd9;
        wait_tick(n);
        check_eq("R7 old divisor holds", n + 5, 20);
        wait_tick(n);
        check_eq("R7 new divisor", n, 40);
        repeat (5) @(negedge clk);
        sync_sel = 1'b0;
        fast_sel = 1'b0;
        wait_tick(n);
        check_eq("R7 old mode holds", n + 5, 40);
        wait_tick(n);
        check_eq("R7 new mode", n, 640);

        // R9: reset in mid-run, then restart with port still enabled
        stop_port();
        divisor = 8'd0;
        port_en = 1'b1;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_eq("R9 tick after mid-run reset", int'(baud_tick), 0);
        check_eq("R9 sample after mid-run reset", int'(sample_tick), 0);
        rst_n = 1'b1;
        wait_tick(n);
        check_eq("R9 restart latency after reset", n, 65);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule